// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O peripheral for 32 pins, arranged as four banks of eight. Each bank decodes its own 64-byte window on a simple register bus. The window holds a direction register, an output data register, a read-only view of the synchronised pad levels, an interrupt type selector, a sticky interrupt status register and an interrupt mask. The mask has separate write-only offsets for setting and for clearing bits. Pad inputs pass through a two-flop synchroniser before they are read or used to detect interrupts.

Software sets up pins by writing the bank registers. A pad drives its output value only when its direction bit selects output. Each pin raises its status bit either on a rising edge of its synchronised input or, in level mode, for as long as the input is high. The block drives one interrupt request, which is the OR of every unmasked status bit in all four banks. Read data is combinational from the address. Writes take effect on the next rising clock edge.

Top module: `bgc_gpio_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pad_oe` all 0), `pad_out` is all 0, every status bit is 0, every mask bit is 1, every pin is in edge mode, and `irq` is 0.
- R2: Pin n maps to bit (n mod 8) of bank (n div 8). Bank b's registers sit at byte address 0x40*b plus the register offset, and address bits [7:6] select the bank.
- R3: Offset 0x10 is the direction register, and it can be read and written. A 1 bit makes the pin an input and a 0 bit makes it an output, so `pad_oe` for a pin is the inverse of its direction bit from the cycle after the write.
- R4: Offset 0x14 is the output data register, and it can be read and written. Its bits drive `pad_out` for the bank's pins from the cycle after the write.
- R5: Offset 0x18 is read-only and returns the pad levels after a two-flop synchroniser. A pad change becomes visible there after the second rising clock edge and not after the first.
- R6: In edge mode (type bit 0), a rising edge of the synchronised input sets the pin's status bit. A falling edge does not set it, and a pin held high does not set it again after it has been cleared. A set bit stays set until software clears it.
- R7: In level mode (type bit 1), the status bit is set on every cycle that the synchronised input is high. A clear write while the input is high has no effect. After the input goes low the bit stays set until a clear write.
- R8: Offset 0x04 reads the raw status. Writing it clears each status bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R9: Offset 0x08 reads the mask. Writing ones to 0x0C sets mask bits and writing ones to 0x08 clears them. Zero bits leave the mask unchanged, and 0x0C reads as 0.
- R10: Offset 0x00 is read-only and returns status AND NOT mask. Writes to it change nothing.
- R11: `irq` is 1 exactly when at least one pin in any bank has its status bit set and its mask bit clear.
- R12: Unused offsets, unaligned addresses and the write-only offset 0x0C read as 0. Bits 31:8 of every read are 0. Writes to unused or read-only offsets change no state.
- R13: Offset 0x20 selects the interrupt type per pin (1 = level, 0 = edge) and reads back its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data, of which bits 7:0 are used |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output value for each pad |
| pad_oe | output | 32 | Output enable for each pad, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a level-mode clear write that arrives while the pad is still high. The bit must survive that write and must only clear once the input has gone low and a second clear write is issued. The stimulus first holds the pad high across the synchroniser latency, then clears the bit, then drops the pad, and reads the raw status after each step. A directed sequence does the same in edge mode on the top bank: it clears a bit while its pad is held high and shows that no new event appears. It also switches the mask around that held bit to show that `irq` follows the mask while the status stays in place.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  // Register offsets inside one bank window
  localparam logic [5:0] OFS_MSTAT    = 6'h00; // read-only masked status
  localparam logic [5:0] OFS_STAT     = 6'h04; // raw status, write-1-to-clear
  localparam logic [5:0] OFS_MASK_CLR = 6'h08; // read mask, write ones to unmask
  localparam logic [5:0] OFS_MASK_SET = 6'h0C; // write ones to mask
  localparam logic [5:0] OFS_DIR      = 6'h10; // 1 = input
  localparam logic [5:0] OFS_OUT      = 6'h14;
  localparam logic [5:0] OFS_IN       = 6'h18; // read-only pad level
  localparam logic [5:0] OFS_TYPE     = 6'h20; // 1 = level, 0 = edge

  localparam int WIN_BITS = 6; // 64-byte window per bank

  // Per-bank register state
  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] dout;
    logic [7:0] itype;
    logic [7:0] mask;
  } bgc_cfg_t;
endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/bgc_bank.sv
module bgc_bank
  import bgc_pkg::*;
#(
  parameter int PINS = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_sync,
  input  logic            wr_en,
  input  logic [5:0]      wr_ofs,
  input  logic [PINS-1:0] wr_data,
  input  logic [5:0]      rd_ofs,
  output logic [DW-1:0]   rd_data,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] stat_q,
  output logic [PINS-1:0] mask_q,
  output logic [PINS-1:0] mstat
);
  logic [PINS-1:0] type_q, prev_q;
  logic [PINS-1:0] dir_d, out_d, type_d, mask_d, stat_d;
  logic [PINS-1:0] clr_bits, rise, evt;
  logic            cfg_we;

  // next-state logic
  always_comb begin
    dir_d    = dir_q;
    out_d    = out_q;
    type_d   = type_q;
    mask_d   = mask_q;
    clr_bits = '0;
    cfg_we   = 1'b0;
    if (wr_en) begin
      case (wr_ofs)
        OFS_DIR:      begin dir_d  = wr_data;            cfg_we = 1'b1; end
        OFS_OUT:      begin out_d  = wr_data;            cfg_we = 1'b1; end
        OFS_TYPE:     begin type_d = wr_data;            cfg_we = 1'b1; end
        OFS_MASK_SET: begin mask_d = mask_q | wr_data;   cfg_we = 1'b1; end
        OFS_MASK_CLR: begin mask_d = mask_q & ~wr_data;  cfg_we = 1'b1; end
        OFS_STAT:     clr_bits = wr_data;
        default:      ;
      endcase
    end
    rise   = pin_sync & ~prev_q;
    evt    = (type_q & pin_sync) | (~type_q & rise);
    // a new event wins over a clear in the same cycle
    stat_d = (stat_q & ~clr_bits) | evt;
  end

  // configuration registers, enabled by a decoded write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      type_q <= '0;
      mask_q <= '1;
    end else if (cfg_we) begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      type_q <= type_d;
      mask_q <= mask_d;
    end
  end

  // event state, updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      stat_q <= stat_d;
      prev_q <= pin_sync;
    end
  end

  assign mstat = stat_q & ~mask_q;

  // read multiplexer
  always_comb begin
    rd_data = '0;
    case (rd_ofs)
      OFS_MSTAT:    rd_data[PINS-1:0] = mstat;
      OFS_STAT:     rd_data[PINS-1:0] = stat_q;
      OFS_MASK_CLR: rd_data[PINS-1:0] = mask_q;
      OFS_DIR:      rd_data[PINS-1:0] = dir_q;
      OFS_OUT:      rd_data[PINS-1:0] = out_q;
      OFS_IN:       rd_data[PINS-1:0] = pin_sync;
      OFS_TYPE:     rd_data[PINS-1:0] = type_q;
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bgc_gpio_ctrl.sv
module bgc_gpio_ctrl
  import bgc_pkg::*;
#(
  parameter  int BANKS       = 4,
  parameter  int PINS        = 8,
  parameter  int DW          = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int NPINS       = BANKS * PINS,
  localparam int SELW        = $clog2(BANKS),
  localparam int AW          = SELW + WIN_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  logic [NPINS-1:0] pad_s;
  bgc_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pad_in),
    .q     (pad_s)
  );

  logic [SELW-1:0]  sel_bank;
  logic [5:0]       ofs;
  logic [DW-1:0]    bank_rd [BANKS];
  logic [NPINS-1:0] stat_all, mask_all, mstat_all, dir_all;
  logic             unused_wdata_hi;

  assign sel_bank        = bus_addr[AW-1:WIN_BITS];
  assign ofs             = bus_addr[WIN_BITS-1:0];
  assign unused_wdata_hi = ^bus_wdata[DW-1:PINS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = bus_wr && (sel_bank == SELW'(b));

    bgc_bank #(.PINS(PINS), .DW(DW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .pin_sync (pad_s[b*PINS +: PINS]),
      .wr_en    (bank_we),
      .wr_ofs   (ofs),
      .wr_data  (bus_wdata[PINS-1:0]),
      .rd_ofs   (ofs),
      .rd_data  (bank_rd[b]),
      .out_q    (pad_out[b*PINS +: PINS]),
      .dir_q    (dir_all[b*PINS +: PINS]),
      .stat_q   (stat_all[b*PINS +: PINS]),
      .mask_q   (mask_all[b*PINS +: PINS]),
      .mstat    (mstat_all[b*PINS +: PINS])
    );
  end

  assign pad_oe    = ~dir_all;
  assign bus_rdata = bank_rd[sel_bank];
  assign irq       = |mstat_all;
endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int BANKS = 4,
  parameter int PINS  = 8,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_wr,
  input logic [DW-1:0]          bus_wdata,
  input logic [DW-1:0]          bus_rdata,
  input logic [BANKS*PINS-1:0]  pad_out,
  input logic [BANKS*PINS-1:0]  pad_oe,
  input logic                   irq,
  input logic [BANKS*PINS-1:0]  stat_all,
  input logic [BANKS*PINS-1:0]  mask_all
);
  // R1: state seen right after reset release
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && !irq));

  // R12: upper read bits are never driven
  assert_rdata_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:PINS] == '0);

  // R11: fully masked means no request; a request needs a status bit
  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_all) |-> !irq);
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|stat_all));

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    localparam logic [AW-1:0] BASE = AW'(b * 64);

    // R3: direction write sets output enable inversely
    assert_dir_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BASE + AW'(16))
      |=> pad_oe[b*PINS +: PINS] == ~$past(bus_wdata[PINS-1:0]));

    // R4: output write reaches the pads
    assert_out_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BASE + AW'(20))
      |=> pad_out[b*PINS +: PINS] == $past(bus_wdata[PINS-1:0]));

    // R9: set and clear offsets touch only the written-one bits
    assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BASE + AW'(12))
      |=> mask_all[b*PINS +: PINS] ==
          ($past(mask_all[b*PINS +: PINS]) | $past(bus_wdata[PINS-1:0])));
    assert_mask_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BASE + AW'(8))
      |=> mask_all[b*PINS +: PINS] ==
          ($past(mask_all[b*PINS +: PINS]) & ~$past(bus_wdata[PINS-1:0])));

    // R6: without a clear write, status bits only accumulate
    assert_stat_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == BASE + AW'(4))
      |=> (stat_all[b*PINS +: PINS] & $past(stat_all[b*PINS +: PINS]))
          == $past(stat_all[b*PINS +: PINS]));
  end
endmodule

bind bgc_gpio_ctrl bgc_checker #(
  .BANKS (BANKS),
  .PINS  (PINS),
  .DW    (DW),
  .AW    (AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .stat_all  (stat_all),
  .mask_all  (mask_all)
);

// File: tb/bgc_gpio_ctrl_bench.sv
module bgc_gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  bgc_gpio_ctrl u_bgc_gpio_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
  );

  // vector: {req[3:0], addr[7:0], wr, data[7:0], pad[31:0]}
  // wr=1 writes data; wr=0 waits 4 cycles then expects data on a read
  localparam int NV = 36;
  localparam logic [52:0] VEC [NV] = '{
    {4'd1,  8'h10, 1'b0, 8'hFF, 32'h0000_0000}, // R1 direction reset
    {4'd1,  8'h08, 1'b0, 8'hFF, 32'h0000_0000}, // R1 mask reset
    {4'd1,  8'h04, 1'b0, 8'h00, 32'h0000_0000}, // R1 status reset
    {4'd2,  8'h50, 1'b1, 8'hF0, 32'h0000_0000}, // R2 bank1 window
    {4'd4,  8'h54, 1'b1, 8'h05, 32'h0000_0000}, // R4
    {4'd4,  8'h54, 1'b0, 8'h05, 32'h0000_0000}, // R4 readback
    {4'd3,  8'h50, 1'b0, 8'hF0, 32'h0000_0000}, // R3 readback
    {4'd5,  8'h58, 1'b0, 8'h10, 32'h0000_1000}, // R5 pin 12 = bank1 bit4
    {4'd2,  8'h18, 1'b0, 8'h00, 32'h0000_1000}, // R2 bank0 unaffected
    {4'd6,  8'h44, 1'b0, 8'h10, 32'h0000_1000}, // R6 rise sets status
    {4'd10, 8'h40, 1'b0, 8'h00, 32'h0000_1000}, // R10 masked
    {4'd9,  8'h48, 1'b1, 8'h10, 32'h0000_1000}, // R9 unmask bit4
    {4'd10, 8'h40, 1'b0, 8'h10, 32'h0000_1000}, // R10 now visible
    {4'd9,  8'h48, 1'b0, 8'hEF, 32'h0000_1000}, // R9 others unchanged
    {4'd6,  8'h44, 1'b0, 8'h10, 32'h0000_0000}, // R6 sticky after fall
    {4'd8,  8'h44, 1'b1, 8'h00, 32'h0000_0000}, // R8 zero write
    {4'd8,  8'h44, 1'b0, 8'h10, 32'h0000_0000}, // R8 kept
    {4'd8,  8'h44, 1'b1, 8'h10, 32'h0000_0000}, // R8 clear
    {4'd8,  8'h44, 1'b0, 8'h00, 32'h0000_0000}, // R8 cleared
    {4'd13, 8'hA0, 1'b1, 8'h01, 32'h0000_0000}, // R13 pin16 level
    {4'd13, 8'hA0, 1'b0, 8'h01, 32'h0000_0000}, // R13 readback
    {4'd7,  8'h84, 1'b0, 8'h01, 32'h0001_0000}, // R7 high sets
    {4'd7,  8'h84, 1'b1, 8'h01, 32'h0001_0000}, // R7 clear while high
    {4'd7,  8'h84, 1'b0, 8'h01, 32'h0001_0000}, // R7 clear ignored
    {4'd7,  8'h84, 1'b0, 8'h01, 32'h0000_0000}, // R7 stays after low
    {4'd7,  8'h84, 1'b1, 8'h01, 32'h0000_0000}, // R7 clear when low
    {4'd7,  8'h84, 1'b0, 8'h00, 32'h0000_0000}, // R7 cleared
    {4'd12, 8'h1C, 1'b0, 8'h00, 32'h0000_0000}, // R12 unused offset
    {4'd12, 8'h0C, 1'b0, 8'h00, 32'h0000_0000}, // R12 write-only offset
    {4'd12, 8'h18, 1'b1, 8'hFF, 32'h0000_0000}, // R12 write read-only
    {4'd12, 8'h18, 1'b0, 8'h00, 32'h0000_0000}, // R12 no effect
    {4'd10, 8'h00, 1'b1, 8'hFF, 32'h0000_0000}, // R10 write ignored
    {4'd10, 8'h00, 1'b0, 8'h00, 32'h0000_0000}, // R10
    {4'd12, 8'h21, 1'b0, 8'h00, 32'h0000_0000}, // R12 unaligned
    {4'd9,  8'h4C, 1'b1, 8'h10, 32'h0000_0000}, // R9 set mask bit4
    {4'd9,  8'h48, 1'b0, 8'hFF, 32'h0000_0000}  // R9 fully masked again
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = {24'h0, d};
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    #1;
    check(req, bus_rdata, {24'h0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pad_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  vr;
      logic [7:0]  va, vd;
      logic        vw;
      logic [31:0] vp;
      {vr, va, vw, vd, vp} = VEC[i];
      pad_in = vp;
      if (vw) bus_write(va, vd);
      else begin
        idle(4);
        bus_read($sformatf("R%0d vec%0d", vr, i), va, vd);
      end
    end

    // R3 / R4: pads of bank1 pins 8..11 drive 0101
    check("R3 pad_oe", pad_oe, 32'h0000_0F00);
    check("R4 pad_out", pad_out, 32'h0000_0500);
    check("R11 idle irq", {31'h0, irq}, 32'h0);

    // R11 / R2: pin 31 is bank3 bit7
    bus_write(8'hC8, 8'h80);
    pad_in = 32'h8000_0000;
    idle(4);
    check("R11 irq set", {31'h0, irq}, 32'h1);
    bus_read("R10 bank3", 8'hC0, 8'h80);
    bus_write(8'hCC, 8'h80);
    check("R11 masked irq", {31'h0, irq}, 32'h0);
    bus_read("R9 status kept under mask", 8'hC4, 8'h80);
    bus_write(8'hC8, 8'h80);
    check("R11 unmasked irq", {31'h0, irq}, 32'h1);
    bus_write(8'hC4, 8'h80);
    check("R8 clear drops irq", {31'h0, irq}, 32'h0);
    idle(4);
    bus_read("R6 held high no reassert", 8'hC4, 8'h00);
    pad_in = '0;

    // R6: falling edge does not set
    pad_in = 32'h0000_0002;
    idle(4);
    bus_write(8'h04, 8'h02);
    pad_in = 32'h0;
    idle(4);
    bus_read("R6 falling edge", 8'h04, 8'h00);

    // R5: two-flop latency on bank0 bit0
    @(negedge clk);
    pad_in = 32'h0000_0001;
    bus_addr = 8'h18;
    @(negedge clk); #1;
    check("R5 after first edge", bus_rdata, 32'h0);
    @(negedge clk); #1;
    check("R5 after second edge", bus_rdata, 32'h1);
    pad_in = 32'h0;
    idle(4);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    check("R1 async pad_oe", pad_oe, 32'h0);
    check("R1 async pad_out", pad_out, 32'h0);
    idle(2);
    rst_n = 1'b1;
    idle(3);
    bus_read("R1 mask after reset", 8'h48, 8'hFF);
    bus_read("R1 type after reset", 8'hA0, 8'h00);
    bus_read("R1 out after reset", 8'h54, 8'h00);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    idle(2);
    summary();
  end
endmodule